// File: doc/BRIEF.md
# Dual Alarm Field Comparator

This block watches a running BCD calendar time and raises alarms when it reaches programmed values. It holds two alarm units that work independently. Each unit has six compare fields: seconds, minutes, hours, date, month and day of week. A field takes part in the comparison only when its enable bit is set. With this, one alarm set can express a weekly, daily, hourly or per-minute alarm, depending on which fields are enabled.

The timekeeping counter sits outside this block. On each seconds tick, the counter presents the current time and pulses `tick`, and the block evaluates both alarms in that cycle. When an alarm matches, its sticky flag is set. Software polls the flags and clears each one with a one-cycle pulse. The flags can also drive an active-low interrupt line, gated per alarm. The alarm registers and their programming path live elsewhere; this block only sees their contents.

Top module: `alarm_cmp_top`

## Requirements
- R1: When `tick` is 1 and every enabled field of alarm n equals the current time, `alarm_flag[n]` reads 1 after that clock edge.
- R2: A flag is never set on a cycle where `tick` is 0, even if the time matches.
- R3: Each alarm field is one byte. Bit 7 of the byte is the field enable, and bits 6:0 hold the BCD compare value. A field whose enable is 0 is ignored, so a different value in that time field does not block the match. Field k of alarm n sits at bits `n*48 + k*8` of `alarm_cfg`. Field k of `cur_time` sits at bits `k*7`. The field order is sec, min, hour, date, month, dow for k = 0 to 5.
- R4: An alarm whose six enable bits are all 0 never sets its flag.
- R5: If any enabled field differs from the current time, the flag is not set on that tick.
- R6: A flag stays at 1 until `alarm_clr[n]` is pulsed. It then reads 0 after that edge.
- R7: If a clear and a new match of the same alarm arrive in the same cycle, the flag stays at 1.
- R8: The two alarms have separate configuration, flags and clears, and one never affects the other.
- R9: `irq_n` is 0 exactly when some alarm has both its flag and its `irq_en` bit at 1. It follows the flags and `irq_en` in the same cycle, with no added register.
- R10: A synchronous reset (`rst` = 1) clears both flags, so `irq_n` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second; the compare is evaluated in that cycle |
| cur_time | input | 42 | Current BCD time, six 7-bit fields |
| alarm_cfg | input | 96 | Two alarms, six bytes each: enable in bit 7, value in bits 6:0 |
| alarm_clr | input | 2 | Per-alarm flag clear pulse |
| irq_en | input | 2 | Per-alarm interrupt enable |
| alarm_flag | output | 2 | Sticky per-alarm match flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Flag results are due one clock edge after the tick, clear or reset cycle that causes them. `irq_n` is due in the same cycle as the flags and `irq_en` it is derived from. The bench drives inputs on the falling edge and lets the next rising edge act on them. At that edge it updates its own flag model, then compares the flags and `irq_n` at the following falling edge, before it changes any input. Directed weekly and daily alarms, the all-disabled case, and the clear-against-set collision are followed by random configurations. These draw field values from a two-value set, so matches happen often.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int NUM_FIELDS = 6;            // sec, min, hour, date, month, dow
    localparam int CFG_W      = 8;            // enable + BCD value
    localparam int VAL_W      = CFG_W - 1;    // BCD compare width
    localparam int ALM_CFG_W  = NUM_FIELDS * CFG_W;
    localparam int TIME_W     = NUM_FIELDS * VAL_W;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } alarm_field_t;

    // A disabled field never blocks a match.
    function automatic logic field_ok(alarm_field_t f, logic [VAL_W-1:0] t);
        return (!f.en) || (f.val == t);
    endfunction
endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  logic [ALM_CFG_W-1:0] cfg,
    input  logic [TIME_W-1:0]    cur_time,
    output logic                 hit,
    output logic                 any_en
);
    logic [NUM_FIELDS-1:0] ok;
    logic [NUM_FIELDS-1:0] en;

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        alarm_field_t fld;
        assign fld   = alarm_field_t'(cfg[k*CFG_W +: CFG_W]);
        assign en[k] = fld.en;
        assign ok[k] = field_ok(fld, cur_time[k*VAL_W +: VAL_W]);
    end

    assign any_en = |en;
    assign hit    = any_en & (&ok);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    input  logic any_en,
    input  logic clr,
    output logic flag
);
    logic set_ev;
    assign set_ev = tick & hit;

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_ev)  flag <= 1'b1;   // set wins over clear
        else if (clr)     flag <= 1'b0;
    end

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> flag);                                   // R1
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick && hit));                       // R2
    AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        !any_en |-> !hit);                                         // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);                                  // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !(tick && hit)) |=> !flag);                        // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && tick && hit) |=> flag);                            // R7
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
    import alarm_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick,
    input  logic [TIME_W-1:0]              cur_time,
    input  logic [NUM_ALARMS*ALM_CFG_W-1:0] alarm_cfg,
    input  logic [NUM_ALARMS-1:0]          alarm_clr,
    input  logic [NUM_ALARMS-1:0]          irq_en,
    output logic [NUM_ALARMS-1:0]          alarm_flag,
    output logic                           irq_n
);
    for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_alarm
        logic hit, any_en;

        alarm_match u_match (
            .cfg      (alarm_cfg[n*ALM_CFG_W +: ALM_CFG_W]),
            .cur_time (cur_time),
            .hit      (hit),
            .any_en   (any_en)
        );

        alarm_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .hit    (hit),
            .any_en (any_en),
            .clr    (alarm_clr[n]),
            .flag   (alarm_flag[n])
        );

        AST_CLR_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            (alarm_flag[n] && !alarm_clr[n]) |=> alarm_flag[n]);   // R8
    end

    assign irq_n = ~|(alarm_flag & irq_en);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (alarm_flag == '0));                               // R10
endmodule

// File: tb/tb_alarm_cmp_top.sv
module tb_alarm_cmp_top;
    localparam int NA = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic         tick;
    logic [41:0]  cur_time;
    logic [95:0]  alarm_cfg;
    logic [1:0]   alarm_clr;
    logic [1:0]   irq_en;
    logic [1:0]   alarm_flag;
    logic         irq_n;

    int errors = 0;
    int checks = 0;
    logic [1:0] mflag;

    always #5 clk = ~clk;

    alarm_cmp_top #(.NUM_ALARMS(NA)) dut (
        .clk(clk), .rst(rst), .tick(tick), .cur_time(cur_time),
        .alarm_cfg(alarm_cfg), .alarm_clr(alarm_clr), .irq_en(irq_en),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic logic exp_hit(logic [47:0] cfg, logic [41:0] t);
        logic any = 1'b0;
        logic all = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (cfg[k*8+7]) begin
                any = 1'b1;
                if (cfg[k*8 +: 7] != t[k*7 +: 7]) all = 1'b0;
            end
        end
        return any & all;
    endfunction

    function automatic logic [7:0] en_b(logic [6:0] v);
        return {1'b1, v};
    endfunction

    // dow, month, date, hour, min, sec
    function automatic logic [41:0] mk_t(logic [6:0] dw, logic [6:0] mo, logic [6:0] dt,
                                         logic [6:0] hr, logic [6:0] mn, logic [6:0] sc);
        return {dw, mo, dt, hr, mn, sc};
    endfunction

    task automatic check(string req);
        logic exp_irq;
        exp_irq = ~|(mflag & irq_en);
        checks++;
        if (alarm_flag !== mflag || irq_n !== exp_irq) begin
            errors++;
            $display("FAIL %s: flags=%b irq_n=%b expected flags=%b irq_n=%b",
                     req, alarm_flag, irq_n, mflag, exp_irq);
        end
    endtask

    // Inputs are stable from the previous falling edge; apply one rising edge.
    task automatic step(string req);
        @(posedge clk);
        for (int n = 0; n < NA; n++) begin
            if (rst) mflag[n] = 1'b0;
            else if (tick && exp_hit(alarm_cfg[n*48 +: 48], cur_time)) mflag[n] = 1'b1;
            else if (alarm_clr[n]) mflag[n] = 1'b0;
        end
        @(negedge clk);
        check(req);
        tick = 1'b0;
        alarm_clr = '0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        mflag = '0;
        rst = 1'b1; tick = 1'b0; cur_time = '0; alarm_cfg = '0;
        alarm_clr = '0; irq_en = 2'b11;
        @(negedge clk);
        step("R10 reset");
        rst = 1'b0;

        // Alarm 0 weekly: dow 3, 08:00; alarm 1 daily 21:30
        alarm_cfg[47:0]  = {en_b(7'h03), 8'h00, 8'h00, en_b(7'h08), en_b(7'h00), 8'h00};
        alarm_cfg[95:48] = {8'h00, 8'h00, 8'h00, en_b(7'h21), en_b(7'h30), 8'h00};
        cur_time = mk_t(7'h3, 7'h5, 7'h14, 7'h08, 7'h00, 7'h00);
        step("R2 match without tick");
        tick = 1'b1; cur_time = mk_t(7'h3, 7'h5, 7'h14, 7'h08, 7'h01, 7'h00);
        step("R5 minute mismatch");
        tick = 1'b1; cur_time = mk_t(7'h3, 7'h5, 7'h14, 7'h08, 7'h00, 7'h27);
        step("R1 R3 weekly match, disabled fields differ");
        irq_en = 2'b00;
        step("R9 irq masked");
        irq_en = 2'b01;
        step("R9 irq asserted");
        step("R6 flag sticky");
        tick = 1'b1; cur_time = mk_t(7'h2, 7'h5, 7'h14, 7'h21, 7'h30, 7'h00);
        step("R8 alarm1 daily independent");
        alarm_clr = 2'b01;
        step("R6 R8 clear alarm0 only");
        tick = 1'b1; alarm_clr = 2'b10;
        step("R7 set beats clear");
        alarm_clr = 2'b10;
        step("R6 clear alarm1");
        alarm_cfg = '0; tick = 1'b1; cur_time = '0;
        step("R4 all disabled");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            for (int n = 0; n < NA; n++)
                for (int k = 0; k < 6; k++)
                    alarm_cfg[n*48 + k*8 +: 8] = {1'($urandom_range(0, 1)) & 1'($urandom_range(0, 1)),
                                                  7'($urandom_range(0, 1))};
            for (int k = 0; k < 6; k++)
                cur_time[k*7 +: 7] = 7'($urandom_range(0, 1));
            tick      = 1'($urandom_range(0, 2) != 0);
            alarm_clr = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            irq_en    = 2'($urandom_range(0, 3));
            rst       = ($urandom_range(0, 199) == 0);
            step("R1 R3 R5 R7 R8 R9 random");
            rst = 1'b0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
    end
endmodule